// File: doc/BRIEF.md
# I2C Register-Bank Target

This block sits behind an I2C bus as a target device and exposes a bank of twenty 8-bit control registers to an external master. It watches the synchronised SCL and SDA lines for START, repeated START and STOP conditions. It compares the first byte of every transfer against its own 7-bit device address and, on a match, acknowledges by pulling SDA low through an output enable. SDA is open drain: the block never drives a high level. It only enables a pull-down.

Writes carry a register index in the byte that follows the address. The data bytes after it land in consecutive registers. A single 5-bit pointer serves both directions, so a read started with no index continues from where the last access of either kind stopped. A random read is an index-only write, then a repeated START and the address with the read flag set. The pointer wraps from the last register back to the first. Indices beyond the bank are folded into range modulo the register count.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset all registers hold zero, the pointer holds index 0, and `sda_oe_o` is low (SDA released).
- R2: The first byte after a START is the 7-bit device address, MSB first, followed by a direction bit (bit 0 of the byte: 1 = read, 0 = write). On a match the block pulls SDA low in the ninth clock (ACK).
- R3: On an address mismatch the block gives no ACK and neither drives SDA nor changes any register or the pointer until the next START.
- R4: In a write, the byte after the address loads the pointer with that value modulo 20 and is acknowledged. Each later byte is stored at the pointer and acknowledged, and the pointer then advances by one.
- R5: The pointer steps from 13h (19) to 00h, so further bytes overwrite the bank from index 0 onward.
- R6: A read that follows the address directly returns the register at the pointer. The pointer advances after every byte transferred in either direction, so it always holds the last accessed index plus one.
- R7: A write carrying only an index, followed by a repeated START and a read address, returns data starting at that index.
- R8: A master ACK after a read byte makes the block send the next register. After a master NACK the block keeps SDA released, and a STOP returns it to idle.
- R9: The block's SDA enable changes only while SCL is low. Read data goes out MSB first, and SDA is released during the master's acknowledge bit.
- R10: A START or repeated START in any state returns the block to address reception and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume a few things about the bus. SCL and SDA already pass through a synchroniser. SDA moves while SCL is high only to form a START or a STOP. Each SCL phase lasts several system clocks, so one edge is seen once and the enable settles before the master samples. The bench master changes SDA only in the middle of an SCL-low phase, holds each phase four clocks, and resolves SDA as the wired-AND of its own level and the block's pull-down. As a result, every START and STOP the block sees is one the master meant to send.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_SUB,
      ST_SUB_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RMACK,
      ST_IGNORE
   } rb_state_e;

   localparam int unsigned DEV_ADDR_W = 7;
   localparam int unsigned BYTE_W     = 8;
endpackage

// File: rtl/i2c_rb_bus_cond.sv
module i2c_rb_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign start_o = scl_q & scl_i & sda_q & ~sda_i;
   assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
   assign rise_o  = ~scl_q & scl_i;
   assign fall_o  = scl_q & ~scl_i;
endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs #(
   parameter int unsigned NUM_REGS = 20,
   parameter int unsigned PTR_W    = 5,
   parameter int unsigned DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [7:0]        sub_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              inc_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [PTR_W-1:0]  ptr_o
);
   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);
   localparam bit               POW2     = (NUM_REGS == (1 << PTR_W));

   logic [DATA_W-1:0] regs_q [NUM_REGS];
   logic [PTR_W-1:0]  ptr_q, ptr_nxt, sub_fold;

   initial assert (NUM_REGS <= (1 << PTR_W) && NUM_REGS > 1)
      else $error("NUM_REGS does not fit the pointer width");

   generate
      if (POW2) begin : g_fold_mask
         assign sub_fold = sub_i[PTR_W-1:0];
      end else begin : g_fold_mod
         assign sub_fold = PTR_W'(32'(sub_i) % NUM_REGS);
      end
   endgenerate

   assign ptr_nxt = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         for (int i = 0; i < int'(NUM_REGS); i++) regs_q[i] <= '0;
      end else begin
         if (wr_i) regs_q[ptr_q] <= wdata_i;
         if (load_i)     ptr_q <= sub_fold;
         else if (inc_i) ptr_q <= ptr_nxt;
      end
   end

   assign rdata_o = regs_q[ptr_q];
   assign ptr_o   = ptr_q;

   // R5
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i && ptr_q == LAST_IDX) |=> (ptr_q == '0));

   // R4
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (32'(ptr_q) < NUM_REGS));
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
   import i2c_rb_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR = 7'h2A,
   parameter int unsigned NUM_REGS = 20,
   parameter int unsigned PTR_W    = 5,
   parameter int unsigned DATA_W   = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe_o
);
   localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

   initial assert (DATA_W == BYTE_W) else $error("register width must be one bus byte");

   logic start_w, stop_w, rise_w, fall_w;
   rb_state_e state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] sh_q, tx_q;
   logic oe_q, mnack_q;
   logic load_w, wr_w, inc_w;
   logic [DATA_W-1:0] rdata_w;
   logic [PTR_W-1:0]  ptr_w;
   logic byte_done;

   i2c_rb_bus_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .start_o(start_w), .stop_o(stop_w), .rise_o(rise_w), .fall_o(fall_w)
   );

   i2c_rb_regs #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .load_i(load_w), .sub_i(sh_q),
      .wr_i(wr_w), .wdata_i(sh_q), .inc_i(inc_w),
      .rdata_o(rdata_w), .ptr_o(ptr_w)
   );

   assign byte_done = fall_w && (cnt_q == CNT_W'(BYTE_W));
   assign load_w = !start_w && !stop_w && state_q == ST_SUB && byte_done;
   assign wr_w   = !start_w && !stop_w && state_q == ST_WDATA && byte_done;
   assign inc_w  = wr_w || (!start_w && !stop_w && state_q == ST_RDATA && byte_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         sh_q    <= '0;
         tx_q    <= '0;
         oe_q    <= 1'b0;
         mnack_q <= 1'b0;
      end else if (start_w) begin
         state_q <= ST_ADDR;
         cnt_q   <= '0;
         oe_q    <= 1'b0;
      end else if (stop_w) begin
         state_q <= ST_IDLE;
         oe_q    <= 1'b0;
      end else begin
         if (rise_w && (state_q == ST_ADDR || state_q == ST_SUB || state_q == ST_WDATA)) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
         end
         unique case (state_q)
            ST_ADDR: if (byte_done) begin
               if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                  oe_q    <= 1'b1;
                  state_q <= ST_ADDR_ACK;
               end else begin
                  state_q <= ST_IGNORE;
               end
            end
            ST_ADDR_ACK: if (fall_w) begin
               cnt_q <= '0;
               if (sh_q[0]) begin
                  tx_q    <= rdata_w;
                  oe_q    <= ~rdata_w[DATA_W-1];
                  state_q <= ST_RDATA;
               end else begin
                  oe_q    <= 1'b0;
                  state_q <= ST_SUB;
               end
            end
            ST_SUB: if (byte_done) begin
               oe_q    <= 1'b1;
               state_q <= ST_SUB_ACK;
            end
            ST_WDATA: if (byte_done) begin
               oe_q    <= 1'b1;
               state_q <= ST_WDATA_ACK;
            end
            ST_SUB_ACK, ST_WDATA_ACK: if (fall_w) begin
               oe_q    <= 1'b0;
               cnt_q   <= '0;
               state_q <= ST_WDATA;
            end
            ST_RDATA: begin
               if (rise_w) cnt_q <= cnt_q + 1'b1;
               if (byte_done) begin
                  oe_q    <= 1'b0;
                  state_q <= ST_RMACK;
               end else if (fall_w && cnt_q != '0) begin
                  tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                  oe_q <= ~tx_q[BYTE_W-2];
               end
            end
            ST_RMACK: begin
               if (rise_w) mnack_q <= sda_i;
               if (fall_w) begin
                  cnt_q <= '0;
                  if (!mnack_q) begin
                     tx_q    <= rdata_w;
                     oe_q    <= ~rdata_w[DATA_W-1];
                     state_q <= ST_RDATA;
                  end else begin
                     state_q <= ST_IGNORE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = oe_q;

   // R9
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_i);

   // R9
   master_ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RMACK) |-> !sda_oe_o);

   // R3
   ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IGNORE) |-> (!sda_oe_o && !wr_w && !load_w && !inc_w));

   // R10
   start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_w |=> (state_q == ST_ADDR && $stable(ptr_w)));

   // R8
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_w |=> (!sda_oe_o && state_q == ST_IDLE));
endmodule

// File: tb/i2c_regbank_target_tb_top.sv
module i2c_regbank_target_tb_top;
   localparam logic [6:0] DEV = 7'h2A;
   localparam int NREG = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic oe;
   logic sda_bus;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   int model [NREG];
   int mptr = 0;

   always #5 clk = ~clk;
   assign sda_bus = sda_m & ~oe;

   i2c_regbank_target #(.DEV_ADDR(DEV)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(oe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int nxt(input int p);
      return (p == NREG - 1) ? 0 : p + 1;
   endfunction

   task automatic bus_start();
      sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(4);
      sda_m = 1'b0; tick(4); scl_m = 1'b0; tick(4);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(4); scl_m = 1'b1; tick(4); sda_m = 1'b1; tick(4);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; tick(4); scl_m = 1'b1; tick(4); scl_m = 1'b0; tick(4);
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(2); b = sda_bus; tick(2);
      scl_m = 1'b0; tick(4);
   endtask

   task automatic wr_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic rd_byte(input logic mack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         v[i] = b;
      end
      sda_m = ~mack; tick(4); scl_m = 1'b1; tick(2);
      chk(!oe, "R9 release in master ack", oe, 0);
      tick(2); scl_m = 1'b0; tick(4);
   endtask

   task automatic write_head(input logic [7:0] sub, input string req);
      logic ack;
      bus_start();
      wr_byte({DEV, 1'b0}, ack);
      chk(ack, {req, " R2 addr ack"}, ack, 1);
      wr_byte(sub, ack);
      chk(ack, {req, " R4 index ack"}, ack, 1);
      mptr = int'(sub) % NREG;
   endtask

   task automatic write_data(input logic [7:0] d[$], input string req);
      logic ack;
      foreach (d[k]) begin
         wr_byte(d[k], ack);
         chk(ack, {req, " R4 data ack"}, ack, 1);
         model[mptr] = int'(d[k]);
         mptr = nxt(mptr);
      end
   endtask

   task automatic read_body(input int n, input string req);
      logic ack;
      logic [7:0] v;
      wr_byte({DEV, 1'b1}, ack);
      chk(ack, {req, " R2 read addr ack"}, ack, 1);
      for (int k = 0; k < n; k++) begin
         rd_byte(k < n - 1, v);
         chk(int'(v) == model[mptr], {req, " data"}, v, model[mptr]);
         mptr = nxt(mptr);
      end
      bus_stop();
      tick(2);
      chk(!oe, {req, " R8 released after stop"}, oe, 0);
   endtask

   task automatic cur_read(input int n, input string req);
      bus_start();
      read_body(n, req);
   endtask

   task automatic rnd_read(input logic [7:0] sub, input int n, input string req);
      write_head(sub, req);
      bus_start();
      read_body(n, req);
   endtask

   initial begin
      logic ack;
      for (int i = 0; i < NREG; i++) model[i] = 0;
      tick(3);
      rst_n = 1'b1;
      tick(2);
      chk(!oe, "R1 sda released after reset", oe, 0);
      cur_read(2, "R1 R6 reset contents");

      write_head(8'h03, "R4");
      write_data('{8'hA1, 8'hB2, 8'hC3}, "R4");
      bus_stop();
      rnd_read(8'h03, 3, "R7 R8 sequential");
      cur_read(1, "R6 current after read");

      write_head(8'h12, "R5");
      write_data('{8'h11, 8'h22, 8'h33}, "R5");
      bus_stop();
      rnd_read(8'h13, 2, "R5 wrap read");

      rnd_read(8'h19, 1, "R4 index folded");

      bus_start();
      wr_byte({7'h15, 1'b0}, ack);
      chk(!ack, "R3 mismatch nack", ack, 0);
      wr_byte(8'h05, ack);
      chk(!ack, "R3 ignored byte", ack, 0);
      wr_byte(8'hEE, ack);
      chk(!ack, "R3 ignored byte", ack, 0);
      bus_stop();
      cur_read(1, "R3 pointer kept");
      rnd_read(8'h05, 1, "R3 register kept");

      write_head(8'h08, "R6");
      write_data('{8'h5A}, "R6");
      bus_stop();
      cur_read(1, "R6 after write");

      write_head(8'h0A, "R10");
      write_data('{8'h77}, "R10");
      bus_start();
      read_body(1, "R10 restart mid write");
      rnd_read(8'h0A, 2, "R10 stored");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule